// File: doc/BRIEF.md
# Single-Level Page Table MMU

This block sits between a requester that issues 32-bit device virtual addresses and the physical bus. It splits each address into a 20-bit virtual page number and a 12-bit offset. It then finds the page's translation in one flat table of 32-bit entries held in external memory. The table holds one entry per 4 KiB page, so a single table spans the whole 4 GiB space. A small fully associative translation cache keeps recent translations, so repeated accesses to a page need no table read.

Software sets up the block through a small register window. That window holds the physical table location, the enable and fault-handling policy, and a scratch page frame to which faulting accesses can be steered. It also holds a sticky fault record with write-1-to-clear bits, and a command that empties the translation cache. The cache holds stale translations after software edits the table. So after any edit, software issues the clear command and polls until the busy indication drops. Each entry carries valid, writable and 1 MiB superpage flags. A superpage translation found in the table is cached once and covers the whole 1 MiB region.

Top module: `pt_mmu`

## Requirements
- R1: With enable (control register 0, bit 0) clear, the physical address is the virtual address zero-extended. No table read is issued, no fault is recorded and the access is not aborted.
- R2: A cache miss with enable set issues exactly one table read, at byte address table_base*4096 + VPN*4. table_base is register 1 and VPN is vaddr[31:12].
- R3: A table entry decodes as follows: bit 28 is valid, bit 29 is writable, bit 31 is superpage and bits 23:0 are the frame number. For a valid, non-superpage entry the physical address is {frame, vaddr[11:0]}.
- R4: A second access to a page already cached returns the same translation and issues no table read.
- R5: A valid entry with the superpage bit set translates to {frame[23:8], vaddr[19:0]}. Any other page in the same 1 MiB region then hits in the cache without a table read.
- R6: An access whose entry has valid clear raises an invalid-entry fault. The fault sets fault status (register 3) bit 0 and stores the virtual address in register 4. The access is aborted when control bit 1 is set. Invalid entries are never cached.
- R7: A write to a valid entry with writable clear raises a write-violation fault. The fault sets status bit 1 and stores the address, and the access is aborted when control bit 3 is set. A read of that page does not fault.
- R8: irq equals (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 4). Writing 1 to a status bit clears it.
- R9: When control bit 5 is set, a faulting access gets the physical address {scratch frame (register 2), vaddr[11:0]}. Non-faulting accesses are unaffected.
- R10: Writing control bit 8 starts a clear of all cached translations. Control bit 8 then reads 1 until the clear ends, within TLB_ENTRIES cycles. Afterwards, every page is fetched from the table again.
- R11: Cache fills replace entries in round-robin order, and a clear returns the order to the first slot. The (TLB_ENTRIES+1)-th distinct fill after a clear evicts the first page filled, and leaves the second page cached.
- R12: req_ready is low while a translation is in progress or a clear is running. Each accepted request yields exactly one single-cycle resp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| resp_valid | output | 1 | Result valid for one cycle |
| resp_paddr | output | 36 | Physical address |
| resp_abort | output | 1 | Access is aborted by an enabled fault abort |
| fetch_valid | output | 1 | Table read request |
| fetch_ready | input | 1 | Table read accepted |
| fetch_addr | output | 36 | Byte address of the table entry |
| fetch_rvalid | input | 1 | Table read data valid |
| fetch_rdata | input | 32 | Table entry |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Enabled pending fault |

## Verification
The hardest state to reach is a full cache with the replacement pointer wrapped. The bench has to know which slot the next fill lands in, and it cannot see the pointer. To reach that state, the bench first issues a clear, which returns the order to the first slot. It then walks nine distinct pages, so the ninth fill must evict the first. Probing one page it expects to hit and one it expects to miss, and counting table reads at the fetch port, exposes the eviction order. A second corner case is the clear window itself: the bench polls the busy bit with reads at every cycle, and confirms at the same time that requests are refused.

// File: rtl/pt_mmu_pkg.sv
package pt_mmu_pkg;

   localparam int PG_SHIFT   = 12;
   localparam int VPN_W      = 20;
   localparam int SUPER_SPAN = 8;

   localparam int PTE_VALID  = 28;
   localparam int PTE_WRITE  = 29;
   localparam int PTE_SUPER  = 31;

   localparam logic [2:0] RA_CTRL    = 3'd0;
   localparam logic [2:0] RA_BASE    = 3'd1;
   localparam logic [2:0] RA_SCRATCH = 3'd2;
   localparam logic [2:0] RA_FSTAT   = 3'd3;
   localparam logic [2:0] RA_FADDR   = 3'd4;

   localparam int CB_EN      = 0;
   localparam int CB_INV_ABT = 1;
   localparam int CB_INV_IRQ = 2;
   localparam int CB_WR_ABT  = 3;
   localparam int CB_WR_IRQ  = 4;
   localparam int CB_REDIR   = 5;
   localparam int CB_CLEAR   = 8;

   typedef struct packed {
      logic en;
      logic inv_abt;
      logic inv_irq;
      logic wr_abt;
      logic wr_irq;
      logic redir;
   } mmu_ctrl_t;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_CHECK,
      WK_FETCH,
      WK_WAIT,
      WK_RESP
   } walk_state_e;

endpackage

// File: rtl/pt_mmu_regs.sv
module pt_mmu_regs
   import pt_mmu_pkg::*;
#(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic               clear_busy,
   input  logic               set_inv,
   input  logic               set_wr,
   input  logic [31:0]        fault_va,
   output mmu_ctrl_t          ctrl,
   output logic [FRAME_W-1:0] table_base,
   output logic [FRAME_W-1:0] scratch_frame,
   output logic               clear_start,
   output logic               irq
);

   logic        wr_ctrl, wr_base, wr_scr, wr_fstat;
   logic [1:0]  pend;
   logic [1:0]  w1c;
   logic [31:0] fva;
   logic        unused_wd;

   assign wr_ctrl  = cfg_we && (cfg_addr == RA_CTRL);
   assign wr_base  = cfg_we && (cfg_addr == RA_BASE);
   assign wr_scr   = cfg_we && (cfg_addr == RA_SCRATCH);
   assign wr_fstat = cfg_we && (cfg_addr == RA_FSTAT);

   assign clear_start = wr_ctrl && cfg_wdata[CB_CLEAR];
   assign w1c         = wr_fstat ? cfg_wdata[1:0] : 2'b00;
   assign unused_wd   = ^{cfg_wdata[31:9], cfg_wdata[7:6]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl          <= '0;
         table_base    <= '0;
         scratch_frame <= '0;
         pend          <= '0;
         fva           <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl.en      <= cfg_wdata[CB_EN];
            ctrl.inv_abt <= cfg_wdata[CB_INV_ABT];
            ctrl.inv_irq <= cfg_wdata[CB_INV_IRQ];
            ctrl.wr_abt  <= cfg_wdata[CB_WR_ABT];
            ctrl.wr_irq  <= cfg_wdata[CB_WR_IRQ];
            ctrl.redir   <= cfg_wdata[CB_REDIR];
         end
         if (wr_base) table_base <= cfg_wdata[FRAME_W-1:0];
         if (wr_scr)  scratch_frame <= cfg_wdata[FRAME_W-1:0];
         pend <= (pend & ~w1c) | {set_wr, set_inv};
         if (set_inv || set_wr) fva <= fault_va;
      end
   end

   assign irq = (pend[0] && ctrl.inv_irq) || (pend[1] && ctrl.wr_irq);

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         RA_CTRL: begin
            cfg_rdata[CB_EN]      = ctrl.en;
            cfg_rdata[CB_INV_ABT] = ctrl.inv_abt;
            cfg_rdata[CB_INV_IRQ] = ctrl.inv_irq;
            cfg_rdata[CB_WR_ABT]  = ctrl.wr_abt;
            cfg_rdata[CB_WR_IRQ]  = ctrl.wr_irq;
            cfg_rdata[CB_REDIR]   = ctrl.redir;
            cfg_rdata[CB_CLEAR]   = clear_busy;
         end
         RA_BASE:    cfg_rdata = 32'(table_base);
         RA_SCRATCH: cfg_rdata = 32'(scratch_frame);
         RA_FSTAT:   cfg_rdata = {30'd0, pend};
         RA_FADDR:   cfg_rdata = fva;
         default:    cfg_rdata = '0;
      endcase
   end

   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fstat && cfg_wdata[0] && !set_inv) |=> !pend[0]);

   assert_fault_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_inv |=> (pend[0] && fva == $past(fault_va)));

endmodule

// File: rtl/pt_mmu_tlb.sv
module pt_mmu_tlb
   import pt_mmu_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               lk_hit,
   output logic [FRAME_W-1:0] lk_frame,
   output logic               lk_wr,
   output logic               lk_super,
   input  logic               fill_en,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               fill_wr,
   input  logic               fill_super,
   input  logic               clear_start,
   output logic               clear_busy
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] ent_v, ent_s, ent_w, hit_vec;
   logic [VPN_W-1:0]   ent_tag [ENTRIES];
   logic [FRAME_W-1:0] ent_fr  [ENTRIES];
   logic [IDX_W-1:0]   rr, clr_idx;
   logic               do_fill;

   assign do_fill = fill_en && !clear_busy && !clear_start;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_way
      logic tag_full, tag_super;
      assign tag_full  = (ent_tag[g] == lk_vpn);
      assign tag_super = (ent_tag[g][VPN_W-1:SUPER_SPAN] == lk_vpn[VPN_W-1:SUPER_SPAN]);
      assign hit_vec[g] = ent_v[g] && (ent_s[g] ? tag_super : tag_full);
   end

   always_comb begin
      lk_frame = '0;
      lk_wr    = 1'b0;
      lk_super = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_frame = lk_frame | ent_fr[i];
            lk_wr    = lk_wr | ent_w[i];
            lk_super = lk_super | ent_s[i];
         end
      end
   end
   assign lk_hit = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v      <= '0;
         ent_s      <= '0;
         ent_w      <= '0;
         rr         <= '0;
         clr_idx    <= '0;
         clear_busy <= 1'b0;
      end else if (clear_start) begin
         clear_busy <= 1'b1;
         clr_idx    <= '0;
         rr         <= '0;
      end else if (clear_busy) begin
         ent_v[clr_idx] <= 1'b0;
         clr_idx        <= clr_idx + 1'b1;
         if (clr_idx == LAST) clear_busy <= 1'b0;
      end else if (do_fill) begin
         ent_v[rr] <= 1'b1;
         ent_s[rr] <= fill_super;
         ent_w[rr] <= fill_wr;
         rr        <= (rr == LAST) ? '0 : rr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         ent_tag[rr] <= fill_vpn;
         ent_fr[rr]  <= fill_frame;
      end
   end

   assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_clear_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_busy && clr_idx == LAST && !clear_start) |=> (!clear_busy && ent_v == '0));

endmodule

// File: rtl/pt_mmu_walk.sv
module pt_mmu_walk
   import pt_mmu_pkg::*;
#(
   parameter int FRAME_W = 24,
   localparam int PA_W   = FRAME_W + PG_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [31:0]        req_vaddr,
   input  logic               req_write,
   output logic               resp_valid,
   output logic [PA_W-1:0]    resp_paddr,
   output logic               resp_abort,
   output logic               fetch_valid,
   input  logic               fetch_ready,
   output logic [PA_W-1:0]    fetch_addr,
   input  logic               fetch_rvalid,
   input  logic [31:0]        fetch_rdata,
   input  mmu_ctrl_t          ctrl,
   input  logic [FRAME_W-1:0] table_base,
   input  logic [FRAME_W-1:0] scratch_frame,
   input  logic               clear_busy,
   output logic [VPN_W-1:0]   lk_vpn,
   input  logic               lk_hit,
   input  logic [FRAME_W-1:0] lk_frame,
   input  logic               lk_wr,
   input  logic               lk_super,
   output logic               fill_en,
   output logic [FRAME_W-1:0] fill_frame,
   output logic               fill_wr,
   output logic               fill_super,
   output logic               set_inv,
   output logic               set_wr,
   output logic [31:0]        fault_va
);

   walk_state_e st;
   logic [31:0]        va_q;
   logic               wr_q, en_q;
   logic [PA_W-1:0]    pa_q;
   logic               abt_q;

   logic               s_valid, s_wr, s_sup;
   logic [FRAME_W-1:0] s_fr;
   logic [PA_W-1:0]    tr_pa, res_pa;
   logic               f_inv, f_wr, res_abt, done;
   logic               unused_pte;

   assign unused_pte = ^{fetch_rdata[30], fetch_rdata[27:FRAME_W]};

   assign lk_vpn   = va_q[31:PG_SHIFT];
   assign fault_va = va_q;

   always_comb begin
      if (st == WK_WAIT) begin
         s_valid = fetch_rdata[PTE_VALID];
         s_wr    = fetch_rdata[PTE_WRITE];
         s_sup   = fetch_rdata[PTE_SUPER];
         s_fr    = fetch_rdata[FRAME_W-1:0];
      end else begin
         s_valid = 1'b1;
         s_wr    = lk_wr;
         s_sup   = lk_super;
         s_fr    = lk_frame;
      end
   end

   always_comb begin
      if (s_sup) tr_pa = {s_fr[FRAME_W-1:SUPER_SPAN], va_q[SUPER_SPAN+PG_SHIFT-1:0]};
      else       tr_pa = {s_fr, va_q[PG_SHIFT-1:0]};
   end

   assign f_inv = en_q && !s_valid;
   assign f_wr  = en_q && s_valid && wr_q && !s_wr;

   always_comb begin
      if (!en_q)                         res_pa = PA_W'(va_q);
      else if (ctrl.redir && (f_inv || f_wr)) res_pa = {scratch_frame, va_q[PG_SHIFT-1:0]};
      else                               res_pa = tr_pa;
   end
   assign res_abt = (f_inv && ctrl.inv_abt) || (f_wr && ctrl.wr_abt);

   assign done = ((st == WK_CHECK) && (!en_q || lk_hit)) ||
                 ((st == WK_WAIT) && fetch_rvalid);

   assign set_inv = done && f_inv;
   assign set_wr  = done && f_wr;

   assign fill_en    = (st == WK_WAIT) && fetch_rvalid && fetch_rdata[PTE_VALID];
   assign fill_frame = fetch_rdata[FRAME_W-1:0];
   assign fill_wr    = fetch_rdata[PTE_WRITE];
   assign fill_super = fetch_rdata[PTE_SUPER];

   assign req_ready   = (st == WK_IDLE) && !clear_busy;
   assign fetch_valid = (st == WK_FETCH);
   assign fetch_addr  = {table_base, {PG_SHIFT{1'b0}}} + PA_W'({lk_vpn, 2'b00});
   assign resp_valid  = (st == WK_RESP);
   assign resp_paddr  = pa_q;
   assign resp_abort  = abt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= WK_IDLE;
         va_q  <= '0;
         wr_q  <= 1'b0;
         en_q  <= 1'b0;
         pa_q  <= '0;
         abt_q <= 1'b0;
      end else begin
         case (st)
            WK_IDLE: if (req_valid && req_ready) begin
               va_q <= req_vaddr;
               wr_q <= req_write;
               en_q <= ctrl.en;
               st   <= WK_CHECK;
            end
            WK_CHECK: st <= done ? WK_RESP : WK_FETCH;
            WK_FETCH: if (fetch_ready) st <= WK_WAIT;
            WK_WAIT:  if (fetch_rvalid) st <= WK_RESP;
            WK_RESP:  st <= WK_IDLE;
            default:  st <= WK_IDLE;
         endcase
         if (done) begin
            pa_q  <= res_pa;
            abt_q <= res_abt;
         end
      end
   end

   assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

   assert_hit_no_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WK_CHECK && lk_hit) |=> !fetch_valid);

   assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   assert_off_no_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !en_q) |-> (!resp_abort && resp_paddr == PA_W'(va_q)));

endmodule

// File: rtl/pt_mmu.sv
module pt_mmu
   import pt_mmu_pkg::*;
#(
   parameter int TLB_ENTRIES = 8,
   parameter int FRAME_W     = 24,
   localparam int PA_W       = FRAME_W + PG_SHIFT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [31:0]     req_vaddr,
   input  logic            req_write,
   output logic            resp_valid,
   output logic [PA_W-1:0] resp_paddr,
   output logic            resp_abort,
   output logic            fetch_valid,
   input  logic            fetch_ready,
   output logic [PA_W-1:0] fetch_addr,
   input  logic            fetch_rvalid,
   input  logic [31:0]     fetch_rdata,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_addr,
   input  logic [31:0]     cfg_wdata,
   output logic [31:0]     cfg_rdata,
   output logic            irq
);

   if (TLB_ENTRIES < 2) begin : g_bad_depth
      $error("pt_mmu: TLB_ENTRIES must be at least 2");
   end
   if (FRAME_W < VPN_W || FRAME_W > 24) begin : g_bad_frame
      $error("pt_mmu: FRAME_W must lie between 20 and 24");
   end

   mmu_ctrl_t          ctrl;
   logic [FRAME_W-1:0] table_base, scratch_frame;
   logic               clear_start, clear_busy;
   logic               set_inv, set_wr;
   logic [31:0]        fault_va;
   logic [VPN_W-1:0]   lk_vpn;
   logic               lk_hit, lk_wr, lk_super;
   logic [FRAME_W-1:0] lk_frame, fill_frame;
   logic               fill_en, fill_wr, fill_super;

   pt_mmu_regs #(.FRAME_W(FRAME_W)) i_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_addr      (cfg_addr),
      .cfg_wdata     (cfg_wdata),
      .cfg_rdata     (cfg_rdata),
      .clear_busy    (clear_busy),
      .set_inv       (set_inv),
      .set_wr        (set_wr),
      .fault_va      (fault_va),
      .ctrl          (ctrl),
      .table_base    (table_base),
      .scratch_frame (scratch_frame),
      .clear_start   (clear_start),
      .irq           (irq)
   );

   pt_mmu_tlb #(.ENTRIES(TLB_ENTRIES), .FRAME_W(FRAME_W)) i_tlb (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_vpn      (lk_vpn),
      .lk_hit      (lk_hit),
      .lk_frame    (lk_frame),
      .lk_wr       (lk_wr),
      .lk_super    (lk_super),
      .fill_en     (fill_en),
      .fill_vpn    (lk_vpn),
      .fill_frame  (fill_frame),
      .fill_wr     (fill_wr),
      .fill_super  (fill_super),
      .clear_start (clear_start),
      .clear_busy  (clear_busy)
   );

   pt_mmu_walk #(.FRAME_W(FRAME_W)) i_walk (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_write     (req_write),
      .resp_valid    (resp_valid),
      .resp_paddr    (resp_paddr),
      .resp_abort    (resp_abort),
      .fetch_valid   (fetch_valid),
      .fetch_ready   (fetch_ready),
      .fetch_addr    (fetch_addr),
      .fetch_rvalid  (fetch_rvalid),
      .fetch_rdata   (fetch_rdata),
      .ctrl          (ctrl),
      .table_base    (table_base),
      .scratch_frame (scratch_frame),
      .clear_busy    (clear_busy),
      .lk_vpn        (lk_vpn),
      .lk_hit        (lk_hit),
      .lk_frame      (lk_frame),
      .lk_wr         (lk_wr),
      .lk_super      (lk_super),
      .fill_en       (fill_en),
      .fill_frame    (fill_frame),
      .fill_wr       (fill_wr),
      .fill_super    (fill_super),
      .set_inv       (set_inv),
      .set_wr        (set_wr),
      .fault_va      (fault_va)
   );

   assert_ready_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clear_start |=> !req_ready);

endmodule

// File: tb/test_pt_mmu.sv
module test_pt_mmu;

   localparam int ENT  = 8;
   localparam int PA_W = 36;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0, req_write = 1'b0;
   logic [31:0]     req_vaddr = '0;
   logic            req_ready, resp_valid, resp_abort;
   logic [PA_W-1:0] resp_paddr, fetch_addr;
   logic            fetch_valid;
   logic            fetch_ready = 1'b1;
   logic            fetch_rvalid = 1'b0;
   logic [31:0]     fetch_rdata = '0;
   logic            cfg_we = 1'b0;
   logic [2:0]      cfg_addr = '0;
   logic [31:0]     cfg_wdata = '0;
   logic [31:0]     cfg_rdata;
   logic            irq;

   always #5 clk = ~clk;

   pt_mmu #(.TLB_ENTRIES(ENT), .FRAME_W(24)) i_pt_mmu (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
      .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_abort(resp_abort),
      .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
      .fetch_rvalid(fetch_rvalid), .fetch_rdata(fetch_rdata),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   int fetch_cnt = 0;
   logic [PA_W-1:0] last_fetch = '0;
   logic [31:0] mem [logic [PA_W-1:0]];

   typedef struct {
      logic [PA_W-1:0] pa;
      logic            abt;
      string           tag;
   } exp_t;
   exp_t sb_q[$];

   localparam logic [31:0] V = 32'h1000_0000;
   localparam logic [31:0] W = 32'h2000_0000;
   localparam logic [31:0] S = 32'h8000_0000;

   function automatic logic [PA_W-1:0] tbl(input logic [19:0] vpn);
      return 36'h0_0010_0000 + {14'd0, vpn, 2'b00};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic xlate(input logic [31:0] va, input logic wr, input logic [PA_W-1:0] pa,
                        input logic abt, input int nfetch, input string tag);
      int f0;
      exp_t e;
      f0 = fetch_cnt;
      e.pa = pa; e.abt = abt; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr;
      @(posedge clk);
      #1 req_valid = 1'b0;
      chk(req_ready == 1'b0, "R12 busy", 64'(req_ready), 64'd0);
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(fetch_cnt - f0 == nfetch, tag, 64'(fetch_cnt - f0), 64'(nfetch));
   endtask

   task automatic wait_clear(output int n);
      logic [31:0] d;
      n = 0;
      do begin
         cfg_rd(3'd0, d);
         n++;
      end while (d[8] && n < 50);
   endtask

   // monitor: pop and compare
   initial begin
      forever begin
         @(negedge clk);
         if (resp_valid) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R12 extra response", 64'(resp_paddr), 64'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(resp_paddr == e.pa, e.tag, 64'(resp_paddr), 64'(e.pa));
               chk(resp_abort == e.abt, e.tag, 64'(resp_abort), 64'(e.abt));
            end
         end
      end
   end

   // table memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (fetch_valid) begin
            logic [PA_W-1:0] a;
            a = fetch_addr;
            fetch_cnt++;
            last_fetch = a;
            @(posedge clk);
            #1 fetch_rvalid = 1'b1;
            fetch_rdata = mem.exists(a) ? mem[a] : 32'd0;
            @(posedge clk);
            #1 fetch_rvalid = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // reset state
      cfg_rd(3'd0, d);
      chk(d == 32'd0, "R10 reset ctrl", 64'(d), 64'd0);
      chk(irq == 1'b0, "R8 reset irq", 64'(irq), 64'd0);
      chk(resp_valid == 1'b0 && req_ready == 1'b1, "R12 reset handshake",
          64'({resp_valid, req_ready}), 64'd1);

      // R1 pass-through while disabled
      xlate(32'h1234_5678, 1'b0, 36'h0_1234_5678, 1'b0, 0, "R1");
      xlate(32'hFFFF_F001, 1'b1, 36'h0_FFFF_F001, 1'b0, 0, "R1");

      cfg_wr(3'd1, 32'h0000_0100);
      mem[tbl(20'h00010)] = V | W | 32'h000A_BCDE;
      mem[tbl(20'h00020)] = V | 32'h0000_0111;
      for (int i = 0; i < 256; i++)
         mem[tbl(20'h00300 + 20'(i))] = S | V | W | (32'h000C_0000 | 32'(i));
      for (int i = 0; i < 9; i++)
         mem[tbl(20'h00040 + 20'(i))] = V | W | (32'h0000_0400 | 32'(i));
      cfg_wr(3'd0, 32'h0000_001F);

      // R2, R3 miss then R4 hit
      xlate(32'h0001_0345, 1'b0, 36'h0_ABCD_E345, 1'b0, 1, "R3");
      chk(last_fetch == 36'h0_0010_0040, "R2 fetch address", 64'(last_fetch), 64'h10_0040);
      xlate(32'h0001_07FF, 1'b1, 36'h0_ABCD_E7FF, 1'b0, 0, "R4");

      // R7 write violation
      xlate(32'h0002_0ABC, 1'b0, 36'h0_0011_1ABC, 1'b0, 1, "R7");
      xlate(32'h0002_0ABD, 1'b1, 36'h0_0011_1ABD, 1'b1, 0, "R7");
      cfg_rd(3'd3, d);
      chk(d == 32'd2, "R7 status", 64'(d), 64'd2);
      cfg_rd(3'd4, d);
      chk(d == 32'h0002_0ABD, "R7 fault address", 64'(d), 64'h2_0ABD);
      chk(irq == 1'b1, "R8 irq on write fault", 64'(irq), 64'd1);
      cfg_wr(3'd3, 32'd2);
      @(negedge clk);
      chk(irq == 1'b0, "R8 irq after clear", 64'(irq), 64'd0);

      // R6 invalid entry
      xlate(32'h0003_0010, 1'b0, 36'h0_0000_0010, 1'b1, 1, "R6");
      cfg_rd(3'd3, d);
      chk(d == 32'd1, "R6 status", 64'(d), 64'd1);
      chk(irq == 1'b1, "R8 irq on invalid", 64'(irq), 64'd1);
      cfg_wr(3'd0, 32'h0000_001B);
      @(negedge clk);
      chk(irq == 1'b0, "R8 irq masked", 64'(irq), 64'd0);
      cfg_rd(3'd3, d);
      chk(d == 32'd1, "R8 status kept while masked", 64'(d), 64'd1);
      cfg_wr(3'd3, 32'd1);
      xlate(32'h0003_0020, 1'b0, 36'h0_0000_0020, 1'b1, 1, "R6 not cached");
      cfg_wr(3'd3, 32'd1);

      // R9 redirect
      cfg_wr(3'd2, 32'h000F_FFFF);
      cfg_wr(3'd0, 32'h0000_0021);
      xlate(32'h0003_00AB, 1'b0, 36'h0_FFFF_F0AB, 1'b0, 1, "R9");
      chk(irq == 1'b0, "R8 no irq when disabled", 64'(irq), 64'd0);
      xlate(32'h0002_0123, 1'b1, 36'h0_FFFF_F123, 1'b0, 0, "R9");
      xlate(32'h0002_0124, 1'b0, 36'h0_0011_1124, 1'b0, 0, "R9");
      cfg_rd(3'd3, d);
      chk(d == 32'd3, "R9 status", 64'(d), 64'd3);
      cfg_wr(3'd3, 32'd3);
      cfg_wr(3'd0, 32'h0000_001F);

      // R5 superpage
      xlate(32'h0030_5123, 1'b0, 36'h0_C000_5123, 1'b0, 1, "R5");
      xlate(32'h003A_B456, 1'b1, 36'h0_C00A_B456, 1'b0, 0, "R5");

      // R10 clear
      cfg_wr(3'd0, 32'h0000_011F);
      cfg_rd(3'd0, d);
      chk(d[8] == 1'b1, "R10 busy seen", 64'(d), 64'h11F);
      chk(req_ready == 1'b0, "R12 ready low in clear", 64'(req_ready), 64'd0);
      wait_clear(n);
      chk(n <= ENT + 1, "R10 clear length", 64'(n), 64'(ENT + 1));
      cfg_rd(3'd0, d);
      chk(d == 32'h0000_001F, "R10 ctrl after clear", 64'(d), 64'h1F);
      mem[tbl(20'h00010)] = V | W | 32'h0005_5555;
      xlate(32'h0001_0000, 1'b0, 36'h0_5555_5000, 1'b0, 1, "R10");
      xlate(32'h0030_5000, 1'b0, 36'h0_C000_5000, 1'b0, 1, "R10");

      // R11 round robin
      cfg_wr(3'd0, 32'h0000_011F);
      wait_clear(n);
      for (int i = 0; i < 9; i++)
         xlate({12'h000, 8'h40 + 8'(i), 12'h010}, 1'b0,
               {24'h000400 | 24'(i), 12'h010}, 1'b0, 1, "R11 fill");
      xlate(32'h0004_1020, 1'b0, 36'h0_0040_1020, 1'b0, 0, "R11 kept");
      xlate(32'h0004_0030, 1'b0, 36'h0_0040_0030, 1'b0, 1, "R11 evicted");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule